// File: doc/BRIEF.md
# Programmable Multifunction Expandable Gate

This block is a purely combinational eight-input gate. A three-bit function select picks one of eight two-level logic functions: plain OR or AND across all eight inputs, their complements, or a two-level form. In the two-level forms the inputs are split into a low group and a high group of four. Each group is reduced on its own, and the two results are then combined with the opposite operator.

An expand input lets instances be chained to build wider gates. It is merged into the second-level combination. Its polarity depends on whether that level is a sum or a product, so an expand input held low never changes the result. For an OR-type sum, the upstream instance supplies the OR of its inputs. For an AND-type sum, it supplies the AND. For a product, it supplies the complement of its own reduction.

An enable controls the output. It produces a data bit and an active-high output-enable, so several instances can share one line. When the block is disabled, the data bit is held at 0.

Top module: `mfgate`

## Requirements
- R1: Select 3'b000 gives the NOR of all eight bits of `dataIn`, and select 3'b001 gives their OR. Bit 2 of `funcSel` is the most significant select bit.
- R2: Select 3'b010 gives (OR of `dataIn[3:0]`) AND (OR of `dataIn[7:4]`). Select 3'b011 gives the complement of that value.
- R3: Select 3'b100 gives the AND of all eight bits of `dataIn`, and select 3'b101 gives the NAND.
- R4: Select 3'b110 gives the complement of (AND of `dataIn[3:0]`) OR (AND of `dataIn[7:4]`). Select 3'b111 gives the uncomplemented value.
- R5: For the sum-type selects (000, 001, 110, 111), `expandIn` is ORed into the second-level sum before any final complement. With `expandIn`=1 the enabled output therefore equals `funcSel[0]`.
- R6: For the product-type selects (010, 011, 100, 101), the complement of `expandIn` is ANDed into the second-level product before any final complement. With `expandIn`=1 the enabled output therefore equals `funcSel[0]`.
- R7: With `expandIn`=0, every select gives exactly the function listed in R1 to R4.
- R8: With `outEnIn`=1, `outEn` is 1. With `outEnIn`=0, both `outEn` and `outData` are 0, whatever the other inputs are.
- R9: Two instances can be chained, with the upstream `outData` driving the downstream `expandIn`, to form a 16-input gate of every function. The upstream select must be the matching one: 001 for downstream 000/001, 101 for 100/101, 000 for 010/011, and 100 for 110/111. In the two-level product forms, the upstream eight inputs act as a third OR group. In the two-level sum forms, they act as a third AND group.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| dataIn | input | NUM_GROUPS*GROUP_W (8) | Data inputs; bits [3:0] form the low group, bits [7:4] the high group |
| expandIn | input | 1 | Expansion input from an upstream instance; tie to 0 when unused |
| funcSel | input | 3 | Function select code |
| outEnIn | input | 1 | Output enable request |
| outData | output | 1 | Selected function value, forced to 0 when disabled |
| outEn | output | 1 | Active-high output enable for a shared line |

## Verification
The bench builds the block with its default values: two groups of four inputs. At this size all 512 combinations of data and expand can be swept under every select code, so each function and both expand polarities are covered exhaustively. A second configuration chains two default instances. It compares the pair against a 16-input behavioural gate, using random and all-zero/all-one vectors for every select. This shows that the group width and the expand polarity line up across the chain.

// File: rtl/mfgate_pkg.sv
package mfgate_pkg;

  // select encodings; bit 2 is the most significant select bit
  typedef enum logic [2:0] {
    FN_NOR    = 3'b000,
    FN_OR     = 3'b001,
    FN_ORAND  = 3'b010,
    FN_ORNAND = 3'b011,
    FN_AND    = 3'b100,
    FN_NAND   = 3'b101,
    FN_ANDNOR = 3'b110,
    FN_ANDOR  = 3'b111
  } funcSel_e;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic groupAnd;  // first level reduces each group with AND (else OR)
    logic outerAnd;  // second level is a product (else a sum)
    logic invert;    // complement the final result
    logic drive;     // output enabled
  } gateCtrl_t;

endpackage

// File: rtl/mfgate_ctrl.sv
module mfgate_ctrl
  import mfgate_pkg::*;
(
  input  logic [2:0] funcSel,
  input  logic       outEnIn,
  output gateCtrl_t  ctrl
);

  always_comb begin
    ctrl = '0;
    ctrl.drive = outEnIn;
    unique case (funcSel_e'(funcSel))
      FN_NOR:    begin ctrl.groupAnd = 1'b0; ctrl.outerAnd = 1'b0; ctrl.invert = 1'b1; end
      FN_OR:     begin ctrl.groupAnd = 1'b0; ctrl.outerAnd = 1'b0; ctrl.invert = 1'b0; end
      FN_ORAND:  begin ctrl.groupAnd = 1'b0; ctrl.outerAnd = 1'b1; ctrl.invert = 1'b0; end
      FN_ORNAND: begin ctrl.groupAnd = 1'b0; ctrl.outerAnd = 1'b1; ctrl.invert = 1'b1; end
      FN_AND:    begin ctrl.groupAnd = 1'b1; ctrl.outerAnd = 1'b1; ctrl.invert = 1'b0; end
      FN_NAND:   begin ctrl.groupAnd = 1'b1; ctrl.outerAnd = 1'b1; ctrl.invert = 1'b1; end
      FN_ANDNOR: begin ctrl.groupAnd = 1'b1; ctrl.outerAnd = 1'b0; ctrl.invert = 1'b1; end
      FN_ANDOR:  begin ctrl.groupAnd = 1'b1; ctrl.outerAnd = 1'b0; ctrl.invert = 1'b0; end
      default:   begin ctrl.groupAnd = 1'b0; ctrl.outerAnd = 1'b0; ctrl.invert = 1'b0; end
    endcase
  end

endmodule

// File: rtl/mfgate_dp.sv
module mfgate_dp
  import mfgate_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 2,
  localparam int IN_W      = GROUP_W * NUM_GROUPS
) (
  input  logic [IN_W-1:0] dataIn,
  input  logic            expandIn,
  input  gateCtrl_t       ctrl,
  output logic            outData
);

  logic [NUM_GROUPS-1:0] grpVal;

  // first level: each group reduced with the selected operator
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_group
    logic [GROUP_W-1:0] slice;
    assign slice     = dataIn[g*GROUP_W +: GROUP_W];
    assign grpVal[g] = ctrl.groupAnd ? (&slice) : (|slice);
  end

  logic outerVal;
  logic result;

  // second level: expand merged with a polarity that keeps 0 neutral
  always_comb begin
    if (ctrl.outerAnd) outerVal = (&grpVal) & ~expandIn;
    else               outerVal = (|grpVal) | expandIn;
    result  = outerVal ^ ctrl.invert;
    outData = result & ctrl.drive;
  end

endmodule

// File: rtl/mfgate.sv
module mfgate
  import mfgate_pkg::*;
#(
  parameter int GROUP_W    = 4,
  parameter int NUM_GROUPS = 2
) (
  input  logic [GROUP_W*NUM_GROUPS-1:0] dataIn,
  input  logic                          expandIn,
  input  logic [2:0]                    funcSel,
  input  logic                          outEnIn,
  output logic                          outData,
  output logic                          outEn
);

  gateCtrl_t ctrl;

  mfgate_ctrl u_ctrl (
    .funcSel (funcSel),
    .outEnIn (outEnIn),
    .ctrl    (ctrl)
  );

  mfgate_dp #(
    .GROUP_W    (GROUP_W),
    .NUM_GROUPS (NUM_GROUPS)
  ) u_dp (
    .dataIn   (dataIn),
    .expandIn (expandIn),
    .ctrl     (ctrl),
    .outData  (outData)
  );

  assign outEn = ctrl.drive;

endmodule

// File: rtl/mfgate_chk.sv
module mfgate_chk #(
  parameter int IN_W = 8
) (
  input logic [IN_W-1:0] dataIn,
  input logic            expandIn,
  input logic [2:0]      funcSel,
  input logic            outEnIn,
  input logic            outData,
  input logic            outEn
);

  always_comb begin
    // R8
    if (!outEnIn) disabled_quiet_chk: assert (!outEn && !outData);
    // R8
    if (outEnIn) enabled_drive_chk: assert (outEn);
    // R5
    if (outEnIn && expandIn && (funcSel == 3'b000 || funcSel == 3'b001 ||
                                funcSel == 3'b110 || funcSel == 3'b111))
      sum_expand_chk: assert (outData == funcSel[0]);
    // R6
    if (outEnIn && expandIn && (funcSel == 3'b010 || funcSel == 3'b011 ||
                                funcSel == 3'b100 || funcSel == 3'b101))
      product_expand_chk: assert (outData == funcSel[0]);
    // R1
    if (outEnIn && funcSel == 3'b000 && (|dataIn))
      nor_any_high_chk: assert (!outData);
    // R3
    if (outEnIn && funcSel == 3'b100 && !(&dataIn))
      and_any_low_chk: assert (!outData);
  end

endmodule

bind mfgate mfgate_chk #(.IN_W(NUM_GROUPS*GROUP_W)) u_chk (
  .dataIn   (dataIn),
  .expandIn (expandIn),
  .funcSel  (funcSel),
  .outEnIn  (outEnIn),
  .outData  (outData),
  .outEn    (outEn)
);

// File: tb/mfgate_bench.sv
`timescale 1ns/1ps
module mfgate_bench;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  int checks = 0;
  int fails  = 0;

  // single instance
  logic [7:0] dIn;
  logic       eIn;
  logic [2:0] sel;
  logic       en;
  logic       oData, oEn;

  mfgate u_mfgate (
    .dataIn(dIn), .expandIn(eIn), .funcSel(sel), .outEnIn(en),
    .outData(oData), .outEn(oEn)
  );

  // chained pair
  logic [7:0] upIn, dnIn;
  logic [2:0] upSel, dnSel;
  logic       upData, upEn, dnData, dnEn;

  mfgate u_up (
    .dataIn(upIn), .expandIn(1'b0), .funcSel(upSel), .outEnIn(1'b1),
    .outData(upData), .outEn(upEn)
  );
  mfgate u_dn (
    .dataIn(dnIn), .expandIn(upData), .funcSel(dnSel), .outEnIn(1'b1),
    .outData(dnData), .outEn(dnEn)
  );

  function automatic int count_ones(logic [7:0] v, int lo, int hi);
    int n = 0;
    for (int i = lo; i <= hi; i++) if (v[i]) n++;
    return n;
  endfunction

  function automatic bit inverted(int code);
    return (code == 0 || code == 3 || code == 5 || code == 6);
  endfunction

  // behavioural 8-input reference
  function automatic bit ref8(int code, logic [7:0] d, bit e);
    bit anyLo = count_ones(d, 0, 3) > 0;
    bit anyHi = count_ones(d, 4, 7) > 0;
    bit allLo = count_ones(d, 0, 3) == 4;
    bit allHi = count_ones(d, 4, 7) == 4;
    bit v;
    case (code)
      0, 1:    v = anyLo || anyHi || e;
      2, 3:    v = anyLo && anyHi && !e;
      4, 5:    v = allLo && allHi && !e;
      default: v = (allLo && allHi) ? 1'b1 : (allLo || allHi || e);
    endcase
    return inverted(code) ? !v : v;
  endfunction

  // behavioural 16-input reference: up8 acts as a third group
  function automatic bit ref16(int code, logic [7:0] lo8, logic [7:0] up8);
    int nLo = count_ones(lo8, 0, 3);
    int nHi = count_ones(lo8, 4, 7);
    int nUp = count_ones(up8, 0, 7);
    bit v;
    case (code)
      0, 1:    v = (nLo + nHi + nUp) > 0;
      2, 3:    v = (nLo > 0) && (nHi > 0) && (nUp > 0);
      4, 5:    v = (nLo + nHi + nUp) == 16;
      default: v = (nLo == 4) || (nHi == 4) || (nUp == 8);
    endcase
    return inverted(code) ? !v : v;
  endfunction

  function automatic logic [2:0] upstream_code(int code);
    case (code)
      0, 1:    return 3'b001;
      2, 3:    return 3'b000;
      4, 5:    return 3'b101;
      default: return 3'b100;
    endcase
  endfunction

  function automatic string req_for(int code, bit e);
    if (e) return (code == 0 || code == 1 || code >= 6) ? "R5" : "R6";
    case (code)
      0, 1:    return "R1/R7";
      2, 3:    return "R2/R7";
      4, 5:    return "R3/R7";
      default: return "R4/R7";
    endcase
  endfunction

  task automatic check(bit got, bit exp, string req);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0b expected %0b (sel=%03b data=%02h exp=%0b en=%0b)",
               req, got, exp, sel, dIn, eIn, en);
    end
  endtask

  task automatic check16(bit got, bit exp, int code);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL R9: got %0b expected %0b (sel=%0d lo=%02h up=%02h)",
               got, exp, code, dnIn, upIn);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    dIn = '0; eIn = 1'b0; sel = '0; en = 1'b0;
    upIn = '0; dnIn = '0; upSel = '0; dnSel = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R8: state under reset with enable low
    check(oEn, 1'b0, "R8");
    check(oData, 1'b0, "R8");
    @(posedge clk); #1 rst = 1'b0;

    // R1..R7: exhaustive per select code
    for (int code = 0; code < 8; code++) begin
      for (int v = 0; v < 512; v++) begin
        @(posedge clk); #1;
        sel = 3'(code); dIn = v[7:0]; eIn = v[8]; en = 1'b1;
        @(negedge clk);
        check(oData, ref8(code, v[7:0], v[8]), req_for(code, v[8]));
        check(oEn, 1'b1, "R8");
      end
    end

    // R8: disabled output ignores every other input
    for (int k = 0; k < 64; k++) begin
      @(posedge clk); #1;
      sel = 3'($urandom_range(0, 7)); dIn = 8'($urandom); eIn = 1'($urandom);
      en = 1'b0;
      @(negedge clk);
      check(oData, 1'b0, "R8");
      check(oEn, 1'b0, "R8");
    end

    // R9: chained pair against a 16-input gate
    for (int code = 0; code < 8; code++) begin
      for (int k = 0; k < 1504; k++) begin
        @(posedge clk); #1;
        dnSel = 3'(code); upSel = upstream_code(code);
        case (k)
          0:       begin dnIn = 8'h00; upIn = 8'h00; end
          1:       begin dnIn = 8'hFF; upIn = 8'hFF; end
          2:       begin dnIn = 8'hFF; upIn = 8'hFE; end
          3:       begin dnIn = 8'h01; upIn = 8'h00; end
          default: begin dnIn = 8'($urandom); upIn = 8'($urandom); end
        endcase
        @(negedge clk);
        check16(dnData, ref16(code, dnIn, upIn), code);
      end
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule